// File: doc/BRIEF.md
# Hysteretic Frequency Lock Detector

This block decides whether a locally generated clock runs at the same frequency as a reference clock. It ignores phase entirely: it counts cycles of the divided oscillator clock over a fixed window of 2^WIN_LOG2 reference cycles and compares that count with the ideal value, which is the window length itself. The absolute difference is the frequency error in counts. With the default window of 16384 cycles, one count is about 61 ppm, so the default thresholds of 5 and 16 counts correspond to roughly 300 ppm and 1000 ppm.

The lock flag has hysteresis. It rises only when the error is inside the tight threshold and falls only when the error exceeds the wide one. Between the two thresholds it keeps its value, so the flag does not chatter when the offset sits near a boundary. The oscillator-side count is held in a free-running Gray-coded counter. The reference domain samples that counter through a synchronizer and decodes it, so the two domains need no handshake. The last measured count is also available as a debug output.

Top module: `freq_lock_det`

## Requirements
- R1: While `rst_n` is low, `lock_o` is 0 and `count_o` is 0. A reset that arrives mid-window discards that window: after release, the lock timing of R7 starts again from zero.
- R2: At the end of a measured window, `lock_o` becomes 1 if |count − 2^WIN_LOG2| < LOCK_THR.
- R3: At the end of a measured window, `lock_o` becomes 0 if |count − 2^WIN_LOG2| > UNLOCK_THR.
- R4: If LOCK_THR ≤ |count − 2^WIN_LOG2| ≤ UNLOCK_THR, `lock_o` keeps its previous value, whether that value is 0 or 1.
- R5: The error is a magnitude. An oscillator that is slow by N counts gets the same verdict as one that is fast by N counts.
- R6: A measurement completes exactly once every 2^WIN_LOG2 reference cycles. At that point `count_o` takes the number of oscillator cycles in the window, give or take one count of sampling quantization, and holds it until the next window ends. `lock_o` changes only in the cycle after a window ends.
- R7: The first window after reset only sets the starting point of the count. The earliest cycle in which `lock_o` can be 1 is the cycle after the second window ends, that is, after 2·2^WIN_LOG2 + 1 reference edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; the window counter and the verdict run on it |
| osc_clk | input | 1 | Divided oscillator clock being measured |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| lock_o | output | 1 | Active-high frequency lock flag, in the reference domain |
| count_o | output | WIN_LOG2+2 | Oscillator cycles counted in the last window (debug); 0 when DEBUG_EN is 0 |

## Verification
The assertions check the following on every reference cycle. A rise of the flag must follow a window whose error was below the tight threshold. A fall must follow a window whose error was above the wide threshold. The flag may not move in any cycle that does not follow a window end. Window ends must be exactly the window length apart. The flag must stay low until two windows have elapsed since reset. The bench scenarios then show the actual values for real frequency offsets, positive and negative, including a mid-band offset that leaves a set flag set and a clear flag clear. They also show that a reset in the middle of a window restarts the lock timing, and that the reported count matches the offset applied.

// File: rtl/lkd_pkg.sv
package lkd_pkg;

   localparam int LKD_MAX_W = 32;

   function automatic logic [LKD_MAX_W-1:0] lkd_bin2gray(input logic [LKD_MAX_W-1:0] b);
      return b ^ (b >> 1);
   endfunction

   function automatic logic [LKD_MAX_W-1:0] lkd_gray2bin(input logic [LKD_MAX_W-1:0] g);
      logic [LKD_MAX_W-1:0] b;
      b[LKD_MAX_W-1] = g[LKD_MAX_W-1];
      for (int i = LKD_MAX_W - 2; i >= 0; i--) begin
         b[i] = b[i+1] ^ g[i];
      end
      return b;
   endfunction

endpackage

// File: rtl/lkd_gray_cnt.sv
// Free-running oscillator-domain counter with a registered Gray output.
module lkd_gray_cnt
   import lkd_pkg::*;
#(
   parameter int W = 16
) (
   input  logic         osc_clk,
   input  logic         rst_n,
   output logic [W-1:0] gray_o
);
   logic [W-1:0] bin_q;
   logic [W-1:0] bin_nxt;

   assign bin_nxt = bin_q + 1'b1;

   always_ff @(posedge osc_clk or negedge rst_n) begin
      if (!rst_n) begin
         bin_q  <= '0;
         gray_o <= '0;
      end else begin
         bin_q  <= bin_nxt;
         gray_o <= W'(lkd_bin2gray(LKD_MAX_W'(bin_nxt)));
      end
   end
endmodule

// File: rtl/lkd_sync.sv
// Multi-stage synchronizer for a Gray-coded vector.
module lkd_sync #(
   parameter int W      = 16,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stage_q[s] <= '0;
         end else if (s == 0) begin
            stage_q[s] <= d_i;
         end else begin
            stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/lkd_window.sv
// Reference-domain window timer: snapshots the decoded oscillator count at each
// window end and produces the count delta over the window.
module lkd_window
   import lkd_pkg::*;
#(
   parameter int WIN_LOG2 = 14,
   parameter int CNT_W    = WIN_LOG2 + 2
) (
   input  logic             ref_clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] osc_gray_i,
   output logic             meas_vld_o,
   output logic [CNT_W-1:0] delta_o
);
   logic [WIN_LOG2-1:0] win_q;
   logic                tick;
   logic                primed_q;
   logic [CNT_W-1:0]    osc_bin;
   logic [CNT_W-1:0]    snap_q;

   assign tick    = &win_q;
   assign osc_bin = CNT_W'(lkd_gray2bin(LKD_MAX_W'(osc_gray_i)));

   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q      <= '0;
         primed_q   <= 1'b0;
         snap_q     <= '0;
         delta_o    <= '0;
         meas_vld_o <= 1'b0;
      end else begin
         win_q      <= win_q + 1'b1;
         meas_vld_o <= tick && primed_q;
         if (tick) begin
            snap_q   <= osc_bin;
            primed_q <= 1'b1;
            if (primed_q) begin
               delta_o <= osc_bin - snap_q;
            end
         end
      end
   end
endmodule

// File: rtl/lkd_hyst.sv
// Error magnitude and two-threshold lock decision.
module lkd_hyst #(
   parameter int WIN_LOG2   = 14,
   parameter int CNT_W      = WIN_LOG2 + 2,
   parameter int LOCK_THR   = 5,
   parameter int UNLOCK_THR = 16
) (
   input  logic             ref_clk,
   input  logic             rst_n,
   input  logic             meas_vld_i,
   input  logic [CNT_W-1:0] delta_i,
   output logic [CNT_W-1:0] err_o,
   output logic             lock_o
);
   localparam logic [CNT_W-1:0] IDEAL  = CNT_W'(1 << WIN_LOG2);
   localparam logic [CNT_W-1:0] THR_IN  = CNT_W'(LOCK_THR);
   localparam logic [CNT_W-1:0] THR_OUT = CNT_W'(UNLOCK_THR);

   logic signed [CNT_W-1:0] diff;

   assign diff  = $signed(delta_i - IDEAL);
   assign err_o = diff[CNT_W-1] ? CNT_W'(-diff) : CNT_W'(diff);

   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_o <= 1'b0;
      end else if (meas_vld_i) begin
         if (err_o < THR_IN) begin
            lock_o <= 1'b1;
         end else if (err_o > THR_OUT) begin
            lock_o <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/freq_lock_det.sv
module freq_lock_det #(
   parameter int WIN_LOG2   = 14,
   parameter int LOCK_THR   = 5,
   parameter int UNLOCK_THR = 16,
   parameter int SYNC_STG   = 2,
   parameter bit DEBUG_EN   = 1'b1,
   localparam int CNT_W     = WIN_LOG2 + 2
) (
   input  logic             ref_clk,
   input  logic             osc_clk,
   input  logic             rst_n,
   output logic             lock_o,
   output logic [CNT_W-1:0] count_o
);
   if (WIN_LOG2 < 4 || CNT_W > 32) begin : g_bad_win
      $error("freq_lock_det: WIN_LOG2 out of range");
   end
   if (LOCK_THR < 1 || LOCK_THR > UNLOCK_THR || UNLOCK_THR >= (1 << WIN_LOG2)) begin : g_bad_thr
      $error("freq_lock_det: thresholds must satisfy 1 <= LOCK_THR <= UNLOCK_THR < window");
   end
   if (SYNC_STG < 2) begin : g_bad_sync
      $error("freq_lock_det: at least two synchronizer stages required");
   end

   logic [CNT_W-1:0] osc_gray;
   logic [CNT_W-1:0] osc_gray_sync;
   logic             meas_vld;
   logic [CNT_W-1:0] delta;
   logic [CNT_W-1:0] err_mag;

   lkd_gray_cnt #(.W(CNT_W)) u_osc_cnt (
      .osc_clk (osc_clk),
      .rst_n   (rst_n),
      .gray_o  (osc_gray)
   );

   lkd_sync #(.W(CNT_W), .STAGES(SYNC_STG)) u_sync (
      .clk   (ref_clk),
      .rst_n (rst_n),
      .d_i   (osc_gray),
      .q_o   (osc_gray_sync)
   );

   lkd_window #(.WIN_LOG2(WIN_LOG2), .CNT_W(CNT_W)) u_window (
      .ref_clk    (ref_clk),
      .rst_n      (rst_n),
      .osc_gray_i (osc_gray_sync),
      .meas_vld_o (meas_vld),
      .delta_o    (delta)
   );

   lkd_hyst #(
      .WIN_LOG2   (WIN_LOG2),
      .CNT_W      (CNT_W),
      .LOCK_THR   (LOCK_THR),
      .UNLOCK_THR (UNLOCK_THR)
   ) u_hyst (
      .ref_clk    (ref_clk),
      .rst_n      (rst_n),
      .meas_vld_i (meas_vld),
      .delta_i    (delta),
      .err_o      (err_mag),
      .lock_o     (lock_o)
   );

   if (DEBUG_EN) begin : g_dbg
      assign count_o = delta;
   end else begin : g_nodbg
      assign count_o = '0;
   end
endmodule

// File: rtl/lkd_chk.sv
module lkd_chk #(
   parameter int WIN_LOG2   = 14,
   parameter int LOCK_THR   = 5,
   parameter int UNLOCK_THR = 16,
   parameter int CNT_W      = WIN_LOG2 + 2
) (
   input logic             ref_clk,
   input logic             rst_n,
   input logic             lock_o,
   input logic             meas_vld,
   input logic [CNT_W-1:0] err
);
   localparam logic [CNT_W-1:0] WIN_M1  = CNT_W'((1 << WIN_LOG2) - 1);
   localparam logic [CNT_W-1:0] TWO_WIN = CNT_W'(2 << WIN_LOG2);

   logic [CNT_W-1:0] gap_q;
   logic             seen_q;
   logic [CNT_W-1:0] since_rst_q;

   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_q       <= '0;
         seen_q      <= 1'b0;
         since_rst_q <= '0;
      end else begin
         if (meas_vld) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
         end else if (gap_q != '1) begin
            gap_q <= gap_q + 1'b1;
         end
         if (since_rst_q < TWO_WIN) begin
            since_rst_q <= since_rst_q + 1'b1;
         end
      end
   end

   a_r2_rise_needs_small_err: assert property (@(posedge ref_clk) disable iff (!rst_n)
      $rose(lock_o) |-> ($past(meas_vld) && ($past(err) < CNT_W'(LOCK_THR))));

   a_r3_fall_needs_large_err: assert property (@(posedge ref_clk) disable iff (!rst_n)
      $fell(lock_o) |-> ($past(meas_vld) && ($past(err) > CNT_W'(UNLOCK_THR))));

   a_r4_hold_between_windows: assert property (@(posedge ref_clk) disable iff (!rst_n)
      !meas_vld |=> $stable(lock_o));

   a_r6_window_period: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (meas_vld && seen_q) |-> (gap_q == WIN_M1));

   a_r7_no_early_lock: assert property (@(posedge ref_clk) disable iff (!rst_n)
      lock_o |-> (since_rst_q >= TWO_WIN));
endmodule

bind freq_lock_det lkd_chk #(
   .WIN_LOG2   (WIN_LOG2),
   .LOCK_THR   (LOCK_THR),
   .UNLOCK_THR (UNLOCK_THR),
   .CNT_W      (CNT_W)
) u_lkd_chk (
   .ref_clk  (ref_clk),
   .rst_n    (rst_n),
   .lock_o   (lock_o),
   .meas_vld (meas_vld),
   .err      (err_mag)
);

// File: tb/test_freq_lock_det.sv
`timescale 1ns/1ps
module test_freq_lock_det;
   localparam int WIN_LOG2 = 10;
   localparam int WIN      = 1 << WIN_LOG2;
   localparam int CNT_W    = WIN_LOG2 + 2;

   logic             ref_clk = 1'b0;
   logic             osc_clk = 1'b0;
   logic             rst_n   = 1'b0;
   logic             lock_o;
   logic [CNT_W-1:0] count_o;
   real              osc_half = 10.0;

   int n_checks = 0;
   int n_errors = 0;
   bit done     = 1'b0;

   freq_lock_det #(.WIN_LOG2(WIN_LOG2), .LOCK_THR(5), .UNLOCK_THR(16)) i_freq_lock_det (
      .ref_clk (ref_clk),
      .osc_clk (osc_clk),
      .rst_n   (rst_n),
      .lock_o  (lock_o),
      .count_o (count_o)
   );

   always #10 ref_clk = ~ref_clk;

   initial begin
      #7;
      forever #(osc_half) osc_clk = ~osc_clk;
   end

   task automatic check_bit(input string tag, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: lock_o actual %0b expected %0b", tag, act, exp);
      end
   endtask

   task automatic check_cnt(input string tag, input int exp);
      int act;
      act = int'(count_o);
      n_checks++;
      if (act < exp - 1 || act > exp + 1) begin
         n_errors++;
         $display("FAIL %s: count_o actual %0d expected %0d (+/-1)", tag, act, exp);
      end
   endtask

   // Oscillator offset in counts per window.
   task automatic set_offset(input int e);
      osc_half = 10.0 * real'(WIN) / real'(WIN + e);
   endtask

   task automatic edges(input int n);
      repeat (n) @(posedge ref_clk);
      @(negedge ref_clk);
   endtask

   task automatic settle(input int e);
      set_offset(e);
      edges(3 * WIN);
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      edges(5);
      check_bit("R1 reset lock", lock_o, 1'b0);
      n_checks++;
      if (count_o !== '0) begin
         n_errors++;
         $display("FAIL R1 reset count: actual %0d expected 0", count_o);
      end
   endtask

   task automatic t_first_lock;
      set_offset(0);
      @(negedge ref_clk);
      rst_n = 1'b1;
      edges(WIN + 10);
      check_bit("R7 no lock after first window", lock_o, 1'b0);
      edges(2 * WIN - 4 - (WIN + 10));
      check_bit("R7 no lock before second verdict", lock_o, 1'b0);
      edges(8);
      check_bit("R7/R2 lock after second window", lock_o, 1'b1);
      check_cnt("R6 count at zero offset", WIN);
   endtask

   task automatic t_hold_high;
      settle(10);
      check_bit("R4 hold high mid band", lock_o, 1'b1);
      check_cnt("R6 count +10", WIN + 10);
      edges(WIN / 3);
      check_cnt("R6 count stable within window", WIN + 10);
   endtask

   task automatic t_release_pos;
      settle(40);
      check_bit("R3 release fast offset", lock_o, 1'b0);
      check_cnt("R6 count +40", WIN + 40);
   endtask

   task automatic t_hold_low;
      settle(10);
      check_bit("R4 hold low mid band", lock_o, 1'b0);
   endtask

   task automatic t_lock_neg;
      settle(-3);
      check_bit("R5/R2 lock slow small offset", lock_o, 1'b1);
      check_cnt("R6 count -3", WIN - 3);
   endtask

   task automatic t_hold_neg;
      settle(-10);
      check_bit("R5/R4 hold high slow mid band", lock_o, 1'b1);
   endtask

   task automatic t_release_neg;
      settle(-40);
      check_bit("R5/R3 release slow offset", lock_o, 1'b0);
      check_cnt("R6 count -40", WIN - 40);
   endtask

   task automatic t_reset_mid;
      settle(0);
      check_bit("R2 relock before reset", lock_o, 1'b1);
      edges(WIN / 2);
      rst_n = 1'b0;
      #1;
      check_bit("R1 lock drops in reset", lock_o, 1'b0);
      edges(3);
      rst_n = 1'b1;
      edges(2 * WIN - 4);
      check_bit("R1 partial window discarded", lock_o, 1'b0);
      edges(8);
      check_bit("R1 relock after restart", lock_o, 1'b1);
   endtask

   initial begin
      t_reset();
      t_first_lock();
      t_hold_high();
      t_release_pos();
      t_hold_low();
      t_lock_neg();
      t_hold_neg();
      t_release_neg();
      t_reset_mid();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      #1_000_000;
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: run did not complete");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end
endmodule